// File: doc/BRIEF.md
# Oversampled Master Clock Divider

This block makes the audio master clock for a serial audio port as a set of clock-enable pulses and a registered square wave. The base clock runs at 512 or 384 times the sample rate, picked by a base-rate select input. A 3-bit multiplier code picks a power-of-two division: 512x down to 32x the sample rate on the 512x base, and 384x down to 48x on the 384x base. Sample rates from 8 kHz to 192 kHz are in range. How the base clock frequency itself is set is outside this block.

The block clock `clk` runs at twice the base rate. This lets even the undivided master clock leave as a registered square wave. A code `c` therefore gives a master-clock period of `2^(c+1)` block cycles: high for the first `2^c` cycles and low for the next `2^c`. A run input starts and stops the output. A gate input freezes the whole divider in place. Both a new code and a stop take effect only at a period boundary, so no output pulse is ever cut short.

Top module: `mcd_mclk_div`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `mclk` is low and neither `mclk_rise` nor `mclk_fall` is asserted.
- R2: With `base_sel` = 0 (512x base), codes 0, 1, 2, 3 and 4 give an `mclk` that is high for 2^code cycles and then low for 2^code cycles (512x, 256x, 128x, 64x, 32x).
- R3: With `base_sel` = 1 (384x base), codes 0, 1, 2 and 3 give an `mclk` that is high for 2^code cycles and then low for 2^code cycles (384x, 192x, 96x, 48x).
- R4: A code the chosen base does not support (5, 6 or 7 on either base, and 4 on the 384x base) behaves as code 0: one cycle high, one cycle low.
- R5: A change of `mult_code` while running takes effect only at the next period boundary; the period already under way keeps its full high and low lengths.
- R6: When `run` falls, `mclk` completes its current period and then stays low, with no further `mclk_rise`.
- R7: While `gate` is high the divider does not advance: one cycle later `mclk` holds its value and no pulse is asserted; after `gate` falls, the period resumes where it stopped.
- R8: `mclk_rise` is high for exactly the first high cycle of each period, and `mclk_fall` for exactly the first low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the base rate |
| rst | input | 1 | Synchronous active-high reset |
| base_sel | input | 1 | 0: 512x base, 1: 384x base |
| mult_code | input | 3 | Power-of-two divide code |
| run | input | 1 | Start (1) or stop (0) the master clock |
| gate | input | 1 | Freeze the divider while high |
| mclk_rise | output | 1 | One-cycle pulse with the first high cycle of each period |
| mclk_fall | output | 1 | One-cycle pulse with the first low cycle of each period |
| mclk | output | 1 | Registered square-wave master clock |

## Verification
All outputs are registered. A `run`, `gate` or boundary decision applied before a rising edge therefore shows on `mclk` and the pulses right after that edge. A new code shows at the first period boundary after the edge that samples it. The bench drives inputs on falling edges and samples on falling edges, so each sample sees the state one register stage after the inputs it drove. The bench measures periods by counting high and low samples, starting at the first `mclk_rise` seen after the inputs change. That first rise is always a period that began under the new settings.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  parameter int CODE_W = 3;

  typedef enum logic {
    BASE_512 = 1'b0,
    BASE_384 = 1'b1
  } base_sel_e;

endpackage

// File: rtl/mcd_code_sel.sv
module mcd_code_sel #(
  parameter int CODE_W = mcd_pkg::CODE_W,
  parameter int MAX_HI = 4,
  parameter int MAX_LO = 3
) (
  input  logic              base_sel,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_eff
);
  import mcd_pkg::*;

  localparam logic [CODE_W-1:0] LIM_HI = CODE_W'(MAX_HI);
  localparam logic [CODE_W-1:0] LIM_LO = CODE_W'(MAX_LO);

  logic [CODE_W-1:0] limit;

  always_comb begin
    limit    = (base_sel_e'(base_sel) == BASE_384) ? LIM_LO : LIM_HI;
    code_eff = (code_in <= limit) ? code_in : '0;
  end

endmodule

// File: rtl/mcd_phase_ctr.sv
module mcd_phase_ctr #(
  parameter int CODE_W = mcd_pkg::CODE_W,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              gate,
  input  logic [CODE_W-1:0] code_eff,
  output logic              mclk,
  output logic              mclk_rise,
  output logic              mclk_fall
);

  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] act;
  logic              running;
  logic [CNT_W:0]    half;
  logic [CNT_W:0]    span;
  logic [CNT_W:0]    nxt;
  logic              last;

  always_comb begin
    half = (CNT_W+1)'(1) << act;
    span = half << 1;
    nxt  = {1'b0, cnt} + (CNT_W+1)'(1);
    last = ({1'b0, cnt} == span - (CNT_W+1)'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      act       <= '0;
      running   <= 1'b0;
      mclk      <= 1'b0;
      mclk_rise <= 1'b0;
      mclk_fall <= 1'b0;
    end else if (gate) begin
      mclk_rise <= 1'b0;
      mclk_fall <= 1'b0;
    end else if (!running || last) begin
      act       <= code_eff;
      cnt       <= '0;
      mclk_fall <= 1'b0;
      running   <= run;
      mclk      <= run;
      mclk_rise <= run;
    end else begin
      cnt       <= nxt[CNT_W-1:0];
      mclk      <= (nxt < half);
      mclk_rise <= 1'b0;
      mclk_fall <= (nxt == half);
    end
  end

endmodule

// File: rtl/mcd_mclk_div.sv
module mcd_mclk_div #(
  parameter int CODE_W   = mcd_pkg::CODE_W,
  parameter int RATIO_HI = 512,
  parameter int RATIO_LO = 384,
  parameter int MIN_HI   = 32,
  parameter int MIN_LO   = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_sel,
  input  logic [CODE_W-1:0] mult_code,
  input  logic              run,
  input  logic              gate,
  output logic              mclk_rise,
  output logic              mclk_fall,
  output logic              mclk
);

  localparam int MAX_HI   = $clog2(RATIO_HI / MIN_HI);
  localparam int MAX_LO   = $clog2(RATIO_LO / MIN_LO);
  localparam int MAX_CODE = (MAX_HI > MAX_LO) ? MAX_HI : MAX_LO;
  localparam int CNT_W    = MAX_CODE + 1;

  logic [CODE_W-1:0] code_eff;

  mcd_code_sel #(
    .CODE_W (CODE_W),
    .MAX_HI (MAX_HI),
    .MAX_LO (MAX_LO)
  ) i_code_sel (
    .base_sel (base_sel),
    .code_in  (mult_code),
    .code_eff (code_eff)
  );

  mcd_phase_ctr #(
    .CODE_W (CODE_W),
    .CNT_W  (CNT_W)
  ) i_phase_ctr (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .gate      (gate),
    .code_eff  (code_eff),
    .mclk      (mclk),
    .mclk_rise (mclk_rise),
    .mclk_fall (mclk_fall)
  );

endmodule

// File: rtl/mcd_mclk_div_chk.sv
module mcd_mclk_div_chk (
  input logic clk,
  input logic rst,
  input logic run,
  input logic gate,
  input logic mclk,
  input logic mclk_rise,
  input logic mclk_fall
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!mclk && !mclk_rise && !mclk_fall));

  assert_stop_no_rise_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mclk_rise);

  assert_gate_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    gate |=> ($stable(mclk) && !mclk_rise && !mclk_fall));

  assert_rise_edge_R8: assert property (@(posedge clk) disable iff (rst)
    mclk_rise |-> (mclk && !$past(mclk)));

  assert_fall_edge_R8: assert property (@(posedge clk) disable iff (rst)
    mclk_fall |-> (!mclk && $past(mclk)));

  assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(mclk_rise && mclk_fall));

endmodule

bind mcd_mclk_div mcd_mclk_div_chk i_mcd_mclk_div_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .gate      (gate),
  .mclk      (mclk),
  .mclk_rise (mclk_rise),
  .mclk_fall (mclk_fall)
);

// File: tb/test_mcd_mclk_div.sv
module test_mcd_mclk_div;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NVEC       = 12;

  // {base_sel, code[2:0], expected half period[5:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 6'd1},  {1'b0, 3'd1, 6'd2},  {1'b0, 3'd2, 6'd4},
    {1'b0, 3'd3, 6'd8},  {1'b0, 3'd4, 6'd16}, {1'b0, 3'd5, 6'd1},
    {1'b0, 3'd7, 6'd1},  {1'b1, 3'd0, 6'd1},  {1'b1, 3'd1, 6'd2},
    {1'b1, 3'd3, 6'd8},  {1'b1, 3'd4, 6'd1},  {1'b1, 3'd6, 6'd1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       base_sel = 1'b0;
  logic [2:0] mult_code = 3'd0;
  logic       run = 1'b0;
  logic       gate = 1'b0;
  logic       mclk_rise, mclk_fall, mclk;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcd_mclk_div i_mcd_mclk_div (
    .clk       (clk),
    .rst       (rst),
    .base_sel  (base_sel),
    .mult_code (mult_code),
    .run       (run),
    .gate      (gate),
    .mclk_rise (mclk_rise),
    .mclk_fall (mclk_fall),
    .mclk      (mclk)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 200 && !mclk_rise; i++) @(negedge clk);
  endtask

  // from a rise sample, count high then low samples; ends at next rise sample
  task automatic measure(output int hi, output int lo, output logic fall_ok);
    hi = 0; lo = 0;
    while (mclk && hi < 100) begin hi++; @(negedge clk); end
    fall_ok = mclk_fall;
    while (!mclk && lo < 100) begin lo++; @(negedge clk); end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int hi, lo, h_exp;
    logic fok;
    string tag;

    run = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(!mclk && !mclk_rise && !mclk_fall, "R1", {mclk, mclk_rise, mclk_fall}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      base_sel  = VEC[v][9];
      mult_code = VEC[v][8:6];
      h_exp     = int'(VEC[v][5:0]);
      if (VEC[v][8:6] > (VEC[v][9] ? 3'd3 : 3'd4)) tag = "R4";
      else tag = VEC[v][9] ? "R3" : "R2";
      @(negedge clk);
      wait_rise();
      measure(hi, lo, fok);
      check(hi == h_exp, tag, hi, h_exp);
      check(lo == h_exp, tag, lo, h_exp);
      check(fok, "R8", fok, 1);
    end

    // R5: code change mid-period does not shorten the period
    base_sel = 1'b0; mult_code = 3'd4;
    @(negedge clk); wait_rise();
    hi = 0;
    repeat (3) begin hi++; @(negedge clk); end
    mult_code = 3'd0;
    while (mclk && hi < 100) begin hi++; @(negedge clk); end
    lo = 0;
    while (!mclk && lo < 100) begin lo++; @(negedge clk); end
    check(hi == 16, "R5", hi, 16);
    check(lo == 16, "R5", lo, 16);
    measure(hi, lo, fok);
    check(hi == 1, "R5", hi, 1);

    // R7: gate freezes the divider mid-period
    mult_code = 3'd2;
    @(negedge clk); wait_rise();
    gate = 1'b1;
    fok = 1'b1;
    repeat (10) begin
      @(negedge clk);
      if (!mclk || mclk_rise || mclk_fall) fok = 1'b0;
    end
    check(fok, "R7", fok, 1);
    gate = 1'b0;
    measure(hi, lo, fok);
    check(hi == 4, "R7", hi, 4);
    check(lo == 4, "R7", lo, 4);

    // R6: stop completes the current period then stays low
    mult_code = 3'd3;
    @(negedge clk); wait_rise();
    run = 1'b0;
    hi = 0;
    while (mclk && hi < 100) begin hi++; @(negedge clk); end
    lo = 0; fok = 1'b1;
    repeat (40) begin
      if (mclk) fok = 1'b0;
      else lo++;
      if (mclk_rise) fok = 1'b0;
      @(negedge clk);
    end
    check(hi == 8, "R6", hi, 8);
    check(fok && lo == 40, "R6", lo, 40);

    // R1: reset while running returns to quiet state
    run = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!mclk && !mclk_rise && !mclk_fall, "R1", {mclk, mclk_rise, mclk_fall}, 0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule